// File: doc/BRIEF.md
# Port Input-Change Wake and Interrupt Detector

This block monitors a general-purpose input port and latches a sticky change flag whenever a participating pin differs from a reference value. The reference is loaded only when software reads the port. A pin takes part in detection only when its direction bit marks it as an input. Pin 0 also drops out when it is assigned to the external-interrupt function.

The latched flag drives two requests, each with its own enable. The wake request brings a sleeping core back to life. The interrupt request asks for service. While a wake request is active, a separate decision output tells the core what to do next. When it is high, the core branches to the interrupt vector. When it is low, the core resumes at the next instruction. All control and status pins are plain level signals with no handshake.

Top module: `pin_change_wake`

## Requirements
- R1: While `rst_n` is low, the synchronizer stages, the reference register and the change flag are all cleared, so after reset `chg_flag_o`, `wake_req_o`, `irq_req_o` and `go_vector_o` are 0.
- R2: Each pin passes through two flip-flops before it is compared. A pin value applied before rising edge k can set `chg_flag_o` on rising edge k+2 at the earliest.
- R3: `chg_flag_o` is set on a rising edge when any participating pin's synchronized value differs from the matching bit of the reference.
- R4: A pin whose `dir_in_i` bit is 0 (output) does not take part in detection. Toggling that pin leaves the flag unchanged.
- R5: When `ext_int_sel_i` is 1, pin 0 does not take part in detection. When it is 0, pin 0 takes part like the other pins.
- R6: A rising edge with `port_rd_i` high loads the synchronized port value into the reference. The comparison made on that same edge still uses the previous reference.
- R7: The flag stays set until a rising edge with `flag_clr_i` high clears it. If a mismatch is present on that same edge, the flag stays set.
- R8: `wake_req_o` is high exactly when the flag is set, `wake_en_i` is 1 and `sleep_i` is 1.
- R9: `irq_req_o` is high exactly when the flag is set and `irq_en_i` is 1.
- R10: `go_vector_o` is high exactly when `wake_req_o`, `gie_i` and `irq_en_i` are all high. While a wake request is active, 0 means resume at the next instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Raw port pin values |
| dir_in_i | input | 8 | Per-pin direction; 1 = input |
| ext_int_sel_i | input | 1 | Pin 0 used as external interrupt input |
| port_rd_i | input | 1 | Port read strobe; captures the reference |
| flag_clr_i | input | 1 | Software write of 0 to the change flag |
| wake_en_i | input | 1 | Allow a port change to wake from sleep |
| irq_en_i | input | 1 | Allow the flag to request an interrupt |
| gie_i | input | 1 | Global interrupt enable |
| sleep_i | input | 1 | Core is sleeping |
| chg_flag_o | output | 1 | Sticky change flag |
| wake_req_o | output | 1 | Wake request |
| irq_req_o | output | 1 | Interrupt request |
| go_vector_o | output | 1 | 1 = branch to vector, 0 = next instruction |

## Verification
The hardest case to reach is a clear that lands on the same edge as a fresh mismatch. The bench creates it by changing a pin while the reference is stale. It then waits for the flag and keeps the mismatch in place while it pulses the clear, so the set must win. A port read and a further clear then show that the flag can drop. Masking is checked by toggling an output-direction pin, and then pin 0 with the external-interrupt select both on and off.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  localparam int unsigned PCW_PORT_W = 8;
  localparam int unsigned PCW_SYNC_N = 2;
  typedef enum logic {RESUME_NEXT = 1'b0, RESUME_VECTOR = 1'b1} resume_e;
endpackage

// File: rtl/pcw_sync.sv
module pcw_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pcw_compare.sv
module pcw_compare #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] synced_i,
  input  logic [WIDTH-1:0] dir_in_i,
  input  logic             ext_int_sel_i,
  input  logic             port_rd_i,
  output logic             hit_o
);
  logic [WIDTH-1:0] ref_q;
  logic [WIDTH-1:0] mask;
  logic [WIDTH-1:0] diff;

  assign mask  = dir_in_i & ~{{(WIDTH-1){1'b0}}, ext_int_sel_i};
  assign diff  = (synced_i ^ ref_q) & mask;
  assign hit_o = |diff;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         ref_q <= '0;
    else if (port_rd_i) ref_q <= synced_i;

  assert_ref_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(port_rd_i)) |-> ref_q == $past(synced_i));

  assert_ext_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_int_sel_i && ((synced_i[WIDTH-1:1] ^ ref_q[WIDTH-1:1]) & dir_in_i[WIDTH-1:1]) == '0)
      |-> !hit_o);
endmodule

// File: rtl/pcw_flag.sv
module pcw_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= hit_i | (flag_o & ~clr_i);

  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> flag_o);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && clr_i && !hit_i) |=> !flag_o);
endmodule

// File: rtl/pin_change_wake.sv
module pin_change_wake
  import pcw_pkg::*;
#(
  parameter int unsigned PORT_W = PCW_PORT_W,
  parameter int unsigned SYNC_N = PCW_SYNC_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pin_i,
  input  logic [PORT_W-1:0] dir_in_i,
  input  logic              ext_int_sel_i,
  input  logic              port_rd_i,
  input  logic              flag_clr_i,
  input  logic              wake_en_i,
  input  logic              irq_en_i,
  input  logic              gie_i,
  input  logic              sleep_i,
  output logic              chg_flag_o,
  output logic              wake_req_o,
  output logic              irq_req_o,
  output logic              go_vector_o
);
  logic [PORT_W-1:0] synced;
  logic              hit;
  logic              flag;
  resume_e           resume;

  pcw_sync #(.WIDTH(PORT_W), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(synced));

  pcw_compare #(.WIDTH(PORT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .synced_i(synced), .dir_in_i(dir_in_i),
    .ext_int_sel_i(ext_int_sel_i), .port_rd_i(port_rd_i), .hit_o(hit));

  pcw_flag u_flag (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .clr_i(flag_clr_i), .flag_o(flag));

  assign resume      = (gie_i && irq_en_i) ? RESUME_VECTOR : RESUME_NEXT;
  assign chg_flag_o  = flag;
  assign wake_req_o  = flag & wake_en_i & sleep_i;
  assign irq_req_o   = flag & irq_en_i;
  assign go_vector_o = wake_req_o & (resume == RESUME_VECTOR);

  assert_wake_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |-> flag);
  assert_irq_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> flag);
  assert_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    go_vector_o |-> (wake_req_o && gie_i));
  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |-> !chg_flag_o);
endmodule

// File: tb/sim_pin_change_wake.sv
module sim_pin_change_wake;
  localparam time PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic [7:0] pin = 0, dir = 0;
  logic ext = 0, rd = 0, clr = 0, wen = 0, ien = 0, gie = 0, slp = 0;
  logic flag_o, wake_o, irq_o, vec_o;
  int tests = 0, fails = 0;

  // reference model state
  logic [7:0] pin_hist[$];
  logic [7:0] m_ref = 0;
  logic       m_flag = 0;

  always #(PERIOD/2) clk = ~clk;

  pin_change_wake u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .dir_in_i(dir),
    .ext_int_sel_i(ext), .port_rd_i(rd), .flag_clr_i(clr),
    .wake_en_i(wen), .irq_en_i(ien), .gie_i(gie), .sleep_i(slp),
    .chg_flag_o(flag_o), .wake_req_o(wake_o), .irq_req_o(irq_o),
    .go_vector_o(vec_o));

  always @(posedge clk) begin
    if (!rst_n) begin
      pin_hist = {8'h00, 8'h00};
      m_ref = 0;
      m_flag = 0;
    end else begin
      logic [7:0] seen;
      logic [7:0] use_mask;
      seen = pin_hist[0];
      use_mask = dir;
      if (ext) use_mask[0] = 1'b0;
      m_flag = (((seen ^ m_ref) & use_mask) != 0) || (m_flag && !clr);
      if (rd) m_ref = seen;
      void'(pin_hist.pop_front());
      pin_hist.push_back(pin);
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    chk("R3/R7 flag", flag_o, m_flag);
    chk("R8 wake", wake_o, m_flag & wen & slp);
    chk("R9 irq", irq_o, m_flag & ien);
    chk("R10 vector", vec_o, m_flag & wen & slp & gie & ien);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    pin_hist = {8'h00, 8'h00};
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset flag", flag_o, 1'b0);
    chk("R1 reset wake", wake_o, 1'b0);
    rst_n = 1;
    dir = 8'hFF;
    repeat (3) tick();

    // R2: latency of the synchronizer
    pin = 8'h04;
    tick(); chk("R2 edge1", flag_o, 1'b0);
    tick(); chk("R2 edge2", flag_o, 1'b0);
    tick(); chk("R2 edge3 R3", flag_o, 1'b1);

    // R7: clear with the mismatch still present, so set wins
    clr = 1; tick(); clr = 0;
    chk("R7 set wins", flag_o, 1'b1);
    // R6: read captures the reference, then clear works
    rd = 1; tick(); rd = 0;
    chk("R6 read edge uses old ref", flag_o, 1'b1);
    clr = 1; tick(); clr = 0;
    chk("R7 cleared", flag_o, 1'b0);
    repeat (3) tick();
    chk("R6 no mismatch after read", flag_o, 1'b0);

    // R4: output pin ignored
    dir = 8'hF7;
    pin = 8'h0C; repeat (5) tick();
    chk("R4 output pin ignored", flag_o, 1'b0);

    // R5: pin 0 ignored with ext select, counted without it
    ext = 1;
    pin = 8'h0D; repeat (5) tick();
    chk("R5 ext pin ignored", flag_o, 1'b0);
    ext = 0; repeat (2) tick();
    chk("R5 pin0 counted", flag_o, 1'b1);

    // R8-R10 request combinations
    slp = 1; wen = 1; ien = 1; gie = 1; tick();
    chk("R10 vector", vec_o, 1'b1);
    gie = 0; tick();
    chk("R10 next instr", vec_o, 1'b0);
    chk("R8 wake", wake_o, 1'b1);
    wen = 0; tick();
    chk("R8 no wake", wake_o, 1'b0);
    ien = 0; tick();
    chk("R9 no irq", irq_o, 1'b0);
    slp = 0; wen = 1; tick();
    chk("R8 awake no wake", wake_o, 1'b0);

    // random phase against the model
    for (int i = 0; i < 400; i++) begin
      pin = $urandom; dir = $urandom | 8'h10; ext = $urandom;
      rd = ($urandom % 4) == 0; clr = ($urandom % 3) == 0;
      wen = $urandom; ien = $urandom; gie = $urandom; slp = $urandom;
      if ((i % 7) != 0) pin = pin_hist[1];
      tick();
    end

    // R1: reset mid-run
    rst_n = 0; #1;
    chk("R1 async reset", flag_o, 1'b0);
    tick();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule